// File: doc/BRIEF.md
# Byte-Beat DMA Engine with Windowed Local Buffer

The engine copies a run of bytes between an external byte-wide memory and a local scratch buffer. The buffer appears to software as a window of device addresses starting at a fixed base. Software loads four 64-bit registers: a source address, a destination address, a byte count and a command word. Setting the run bit in the command starts a transfer. The direction bit decides which of the two addresses falls inside the buffer window and which addresses external memory. After a fixed start delay the engine checks the window bounds. If the range fits, it moves one byte per granted beat over a request/grant port. It then clears the run bit and, if the command asked for it, emits a one-cycle completion interrupt pulse. A range that does not fit moves nothing and raises a sticky error flag.

The controller is a five-state machine. IDLE waits for an accepted command (IDLE to DELAY). DELAY counts the start delay and then goes to MOVE if the range passes the check, or to REJECT if it fails. MOVE issues beats and, on the grant of the final beat, goes to DONE. DONE clears run, pulses the interrupt if it was enabled, and returns to IDLE. REJECT sets the error flag, clears run, and returns to IDLE.

Top module: `dma_engine`

## Requirements
- R1: Register offsets are 0x80 source, 0x88 destination, 0x90 count and 0x98 command. A write of size 8 loads all 64 bits. A write of size 4 loads the low 32 bits zero-extended. Writes of any other size are ignored. `reg_rdata` shows the register at `reg_addr`, and any other offset reads as all ones.
- R2: Command bit 0 is run, bit 1 is direction and bit 2 is interrupt enable. A command write with bit 0 clear changes nothing and starts nothing. An accepted command raises `busy` on the next cycle.
- R3: While run is set, writes to all four registers are ignored.
- R4: `mem_req` stays low for START_DELAY cycles after the edge that accepts a command, and rises one cycle later when the range is valid.
- R5: Direction 0 reads `count` bytes from external addresses (masked source)+i and stores them at buffer offset (destination − base)+i.
- R6: Direction 1 reads buffer offset (source − base)+i and writes it to external address (masked destination)+i.
- R7: Before beat i is added, the external start address keeps only its low MASK_BITS bits.
- R8: The buffer range [a, a+count) must lie inside [base, base+depth) with a nonzero count and no wrap. A failing range issues no request, sets `err`, clears run and gives no interrupt.
- R9: `busy` falls one cycle after the final granted beat. If bit 2 was set, `done_irq` is high for exactly that one cycle. Otherwise it stays low.
- R10: `err` stays set until the next accepted command clears it.
- R11: Each cycle with `mem_req` and `mem_gnt` both high moves exactly one byte. While the grant is low, the request and the address hold.
- R12: After reset, all registers read 0, and `busy`, `err`, `mem_req` and `done_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for writes and reads |
| reg_wdata | input | REG_W | Write data |
| reg_size | input | 4 | Access size in bytes (4 or 8 accepted) |
| reg_rdata | output | REG_W | Register selected by reg_addr |
| mem_req | output | 1 | External beat request |
| mem_we | output | 1 | Beat is a write to external memory |
| mem_addr | output | REG_W | External byte address |
| mem_wdata | output | 8 | Byte written to external memory |
| mem_gnt | input | 1 | Beat completes in this cycle |
| mem_rdata | input | 8 | Byte read from external memory, valid with grant |
| busy | output | 1 | Run bit of the command register |
| err | output | 1 | Sticky range-rejection flag |
| done_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The bench builds the engine with a 64-byte buffer, an 8-bit external mask and a start delay of 4 cycles. With a 64-byte buffer the sweep can reach every window edge: a full-window copy, a range ending exactly at the limit, a single byte at the top, and ranges one byte past either end. With an 8-bit mask, a 256-byte external model holds every reachable address, so junk in the upper address bits must be stripped for the data to land correctly. The short delay lets each start be timed cycle by cycle, and a grant that drops every third cycle exercises the hold rule.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DELAY,
        S_MOVE,
        S_DONE,
        S_REJECT
    } dma_state_e;

    localparam logic [7:0] OFF_SRC = 8'h80;
    localparam logic [7:0] OFF_DST = 8'h88;
    localparam logic [7:0] OFF_CNT = 8'h90;
    localparam logic [7:0] OFF_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int REG_W  = 64,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [3:0]        size,
    input  logic              clear_run,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  src,
    output logic [REG_W-1:0]  dst,
    output logic [REG_W-1:0]  cnt,
    output logic [REG_W-1:0]  cmd,
    output logic              start
);
    localparam logic [REG_W-1:0] LOW32 = {{(REG_W-32){1'b0}}, {32{1'b1}}};

    logic             size_ok;
    logic             wr_ok;
    logic [REG_W-1:0] wval;

    assign size_ok = (size == 4'd4) || (size == 4'd8);
    assign wval    = (size == 4'd4) ? (wdata & LOW32) : wdata;
    assign wr_ok   = wr_en && size_ok && !cmd[CMD_RUN];
    assign start   = wr_ok && (addr == REG_AW'(OFF_CMD)) && wval[CMD_RUN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
            cmd <= '0;
        end else if (wr_ok) begin
            if (addr == REG_AW'(OFF_SRC)) src <= wval;
            if (addr == REG_AW'(OFF_DST)) dst <= wval;
            if (addr == REG_AW'(OFF_CNT)) cnt <= wval;
            if (start)                    cmd <= wval;
        end else if (clear_run) begin
            cmd[CMD_RUN] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '1;
        if (addr == REG_AW'(OFF_SRC)) rdata = src;
        if (addr == REG_AW'(OFF_DST)) rdata = dst;
        if (addr == REG_AW'(OFF_CNT)) rdata = cnt;
        if (addr == REG_AW'(OFF_CMD)) rdata = cmd;
    end

    // R3: registers frozen while a transfer is pending
    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd[CMD_RUN] |=> $stable(src) && $stable(dst) && $stable(cnt));

    // R2: a command write without run leaves the command untouched
    p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_AW'(OFF_CMD) && !wdata[CMD_RUN] && !clear_run)
            |=> $stable(cmd));

endmodule

// File: rtl/dma_range_chk.sv
module dma_range_chk #(
    parameter int              REG_W     = 64,
    parameter longint unsigned WIN_BASE  = 64'h40000,
    parameter int              BUF_DEPTH = 4096,
    localparam int             BUF_AW    = $clog2(BUF_DEPTH)
) (
    input  logic [REG_W-1:0]  addr,
    input  logic [REG_W-1:0]  cnt,
    output logic              ok,
    output logic [BUF_AW-1:0] offset
);
    localparam logic [REG_W-1:0] BASE_V = REG_W'(WIN_BASE);
    localparam logic [REG_W:0]   LIMIT  = (REG_W+1)'(WIN_BASE + 64'(BUF_DEPTH));

    logic [REG_W:0]   end_x;
    logic [REG_W-1:0] off_full;

    assign end_x    = {1'b0, addr} + {1'b0, cnt};
    assign off_full = addr - BASE_V;
    assign ok       = (addr >= BASE_V) && (cnt != '0) && (end_x <= LIMIT);
    assign offset   = off_full[BUF_AW-1:0];

    // R8: an accepted range always starts inside the buffer
    always_comb begin
        if (ok) begin
            a_offset_in_window_r8: assert (off_full < REG_W'(BUF_DEPTH));
        end
    end

endmodule

// File: rtl/dma_buf.sv
module dma_buf #(
    parameter int  DEPTH = 4096,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int              REG_W       = 64,
    parameter int              REG_AW      = 8,
    parameter int              BUF_DEPTH   = 4096,
    parameter longint unsigned WIN_BASE    = 64'h40000,
    parameter int              MASK_BITS   = 28,
    parameter int              START_DELAY = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [3:0]        reg_size,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              err,
    output logic              done_irq
);
    localparam int BUF_AW = $clog2(BUF_DEPTH);
    localparam int IDX_W  = BUF_AW + 1;
    localparam int DLY_W  = $clog2(START_DELAY + 1);
    localparam logic [REG_W-1:0] EXT_MASK = (MASK_BITS >= REG_W) ? {REG_W{1'b1}}
                                          : ((REG_W'(1) << MASK_BITS) - REG_W'(1));

    dma_state_e        state_q, state_d;
    logic [REG_W-1:0]  src, dst, cnt, cmd;
    logic              start, clear_run;
    logic              dir, range_ok, last_beat, beat, dly_last;
    logic [REG_W-1:0]  buf_side, ext_side;
    logic [BUF_AW-1:0] offset, buf_idx;
    logic [IDX_W-1:0]  idx_q;
    logic [DLY_W-1:0]  dly_q;
    logic              err_q, irq_q;
    logic [7:0]        buf_rdata;

    dma_regs #(.REG_W(REG_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .size(reg_size), .clear_run(clear_run),
        .rdata(reg_rdata), .src(src), .dst(dst), .cnt(cnt), .cmd(cmd),
        .start(start)
    );

    assign dir      = cmd[CMD_DIR];
    assign buf_side = dir ? src : dst;
    assign ext_side = dir ? dst : src;

    dma_range_chk #(.REG_W(REG_W), .WIN_BASE(WIN_BASE), .BUF_DEPTH(BUF_DEPTH)) u_chk (
        .addr(buf_side), .cnt(cnt), .ok(range_ok), .offset(offset)
    );

    assign buf_idx   = offset + idx_q[BUF_AW-1:0];
    assign last_beat = (REG_W'(idx_q) + REG_W'(1)) == cnt;
    assign dly_last  = dly_q == DLY_W'(START_DELAY - 1);

    dma_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .we(beat && !dir), .waddr(buf_idx), .wdata(mem_rdata),
        .raddr(buf_idx), .rdata(buf_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_req   = 1'b0;
        clear_run = 1'b0;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_DELAY;
            S_DELAY:  if (dly_last) state_d = range_ok ? S_MOVE : S_REJECT;
            S_MOVE: begin
                mem_req = 1'b1;
                if (mem_gnt && last_beat) state_d = S_DONE;
            end
            S_DONE: begin
                clear_run = 1'b1;
                state_d   = S_IDLE;
            end
            S_REJECT: begin
                clear_run = 1'b1;
                state_d   = S_IDLE;
            end
            default:  state_d = S_IDLE;
        endcase
    end

    assign beat      = mem_req && mem_gnt;
    assign mem_we    = mem_req && dir;
    assign mem_addr  = (ext_side & EXT_MASK) + REG_W'(idx_q);
    assign mem_wdata = buf_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            idx_q <= '0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= (state_q == S_DONE) && cmd[CMD_IRQ];
            if (start) begin
                dly_q <= '0;
                idx_q <= '0;
                err_q <= 1'b0;
            end else begin
                if (state_q == S_DELAY)  dly_q <= dly_q + DLY_W'(1);
                if (beat)                idx_q <= idx_q + IDX_W'(1);
                if (state_q == S_REJECT) err_q <= 1'b1;
            end
        end
    end

    assign busy     = cmd[CMD_RUN];
    assign err      = err_q;
    assign done_irq = irq_q;

    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr));
    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy);
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state_q == S_IDLE);
    p_reject_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_REJECT |=> err && !busy && !mem_req);

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 4;
    localparam int DEPTH      = 64;
    localparam longint unsigned BASE = 64'h40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h80;
    logic [63:0] reg_wdata = '0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, mem_gnt, busy, err, done_irq;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  ext [256];
    int          checks = 0, fails = 0, beat = 0, gcnt = 0;
    logic [63:0] exp_base = '0;
    bit          req_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_engine #(.BUF_DEPTH(DEPTH), .WIN_BASE(BASE), .MASK_BITS(8), .START_DELAY(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_size(reg_size), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .busy(busy), .err(err), .done_irq(done_irq)
    );

    assign mem_rdata = ext[mem_addr[7:0]];

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // external memory model; grant drops every third cycle
    always @(negedge clk) begin
        mem_gnt = (gcnt % 3) != 2;
        gcnt++;
        #1;
        if (rst_n && mem_req && mem_gnt) begin
            chk("R7 R11 beat address", mem_addr, exp_base + 64'(beat));
            if (mem_we) ext[mem_addr[7:0]] = mem_wdata;
            beat++;
            req_seen = 1;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; reg_size = s;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_cmd(input logic [63:0] c, input bit moves);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h98; reg_wdata = c; reg_size = 4'd8;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #2;
        chk("R2 busy after accept", 64'(busy), 1);
        chk("R10 err cleared by accept", 64'(err), 0);
        for (int i = 0; i < D; i++) begin
            if (i > 0) begin @(negedge clk); #2; end
            chk("R4 no request during delay", 64'(mem_req), 0);
        end
        @(negedge clk); #2;
        chk("R4 request after delay", 64'(mem_req), 64'(moves));
    endtask

    task automatic wait_done(input int exp_irq);
        int irqs = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done_irq) irqs++;
            if (!busy) break;
            @(negedge clk); #2;
        end
        chk("R9 busy falls", 64'(busy), 0);
        chk("R9 irq pulses", 64'(irqs), 64'(exp_irq));
        @(negedge clk); #2;
        chk("R9 irq one cycle", 64'(done_irq), 0);
    endtask

    task automatic xfer(input bit dir, input logic [63:0] s, input logic [63:0] d,
                        input int len, input bit irq);
        wr(8'h80, s, 4'd8);
        wr(8'h88, d, 4'd8);
        wr(8'h90, 64'(len), 4'd8);
        exp_base = (dir ? d : s) & 64'hFF;
        beat = 0;
        start_cmd({61'b0, irq, dir, 1'b1}, 1);
        wait_done(irq ? 1 : 0);
        chk(dir ? "R6 beat count" : "R5 beat count", 64'(beat), 64'(len));
    endtask

    task automatic reject(input logic [63:0] a, input logic [63:0] len);
        wr(8'h80, 64'h10, 4'd8);
        wr(8'h88, a, 4'd8);
        wr(8'h90, len, 4'd8);
        req_seen = 0;
        start_cmd(64'h5, 0);
        wait_done(0);
        chk("R8 error set", 64'(err), 1);
        chk("R8 no data moved", 64'(req_seen), 0);
    endtask

    initial begin
        logic [63:0] v;
        int offs [5] = '{0, 5, 60, 63, 30};
        int lens [5] = '{64, 20, 4, 1, 7};
        int exts [5] = '{16, 0, 64, 127, 51};
        for (int i = 0; i < 256; i++) ext[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R12 reset state
        chk("R12 busy", 64'(busy), 0);
        chk("R12 err", 64'(err), 0);
        chk("R12 req", 64'(mem_req), 0);
        chk("R12 irq", 64'(done_irq), 0);
        rd(8'h80, v); chk("R12 src", v, 0);
        rd(8'h98, v); chk("R12 cmd", v, 0);

        // R1 access sizes and decode
        wr(8'h80, 64'h1234_5678_9ABC_DEF0, 4'd8);
        rd(8'h80, v); chk("R1 size8", v, 64'h1234_5678_9ABC_DEF0);
        wr(8'h88, 64'hFFFF_FFFF_0000_0011, 4'd4);
        rd(8'h88, v); chk("R1 size4", v, 64'h11);
        wr(8'h90, 64'h77, 4'd2);
        rd(8'h90, v); chk("R1 bad size", v, 0);
        rd(8'h40, v); chk("R1 unmapped", v, 64'hFFFF_FFFF_FFFF_FFFF);

        // R2 discarded command
        wr(8'h98, 64'h6, 4'd8);
        rd(8'h98, v); chk("R2 cmd unchanged", v, 0);
        repeat (D + 3) begin
            @(negedge clk); #2;
            chk("R2 no start", 64'(busy | mem_req), 0);
        end

        // R5 R6 R7 sweep of window edges with junk above the mask
        for (int k = 0; k < 5; k++) begin
            for (int j = 0; j < lens[k]; j++) ext[128 + j] = ~pat(exts[k] + j);
            xfer(0, 64'hABCD_0000_0000_0000 | 64'(exts[k]), BASE + 64'(offs[k]), lens[k], k[0]);
            rd(8'h98, v); chk("R2 run cleared, bits kept", v, {61'b0, k[0], 2'b00});
            xfer(1, BASE + 64'(offs[k]), 64'h5500_0000_0000_0080, lens[k], !k[0]);
            for (int j = 0; j < lens[k]; j++)
                chk("R5 R6 round trip", 64'(ext[128 + j]), 64'(pat(exts[k] + j)));
        end

        // R3 writes ignored while busy
        wr(8'h80, 64'h20, 4'd8);
        wr(8'h88, BASE, 4'd8);
        wr(8'h90, 64'd40, 4'd8);
        exp_base = 64'h20; beat = 0;
        start_cmd(64'h1, 1);
        wr(8'h80, 64'h0, 4'd8);
        wr(8'h90, 64'h3, 4'd4);
        wr(8'h98, 64'h7, 4'd8);
        rd(8'h80, v); chk("R3 src locked", v, 64'h20);
        rd(8'h90, v); chk("R3 cnt locked", v, 64'd40);
        rd(8'h98, v); chk("R3 cmd locked", v, 64'h1);
        wait_done(0);
        chk("R3 full length moved", 64'(beat), 40);

        // R8 rejected ranges
        reject(BASE + 64'd60, 64'd5);
        reject(BASE, 64'd0);
        reject(BASE - 64'd1, 64'd2);
        reject(BASE + 64'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reject(BASE + 64'd64, 64'd1);

        // R10 err sticky until an accepted command
        wr(8'h98, 64'h2, 4'd8);
        chk("R10 err kept after discard", 64'(err), 1);
        xfer(0, 64'h0, BASE, 8, 1);
        chk("R10 err stays clear", 64'(err), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule